// File: doc/BRIEF.md
# Low-Power Mode and Wake-Up Controller

This block sequences the power modes of a small microcontroller core. A one-cycle halt strobe from the running core selects one of three low-power modes. The choice depends on two control bits: an idle-enable bit and a bit that keeps the system oscillator on. The block drives separate enables for the system clock, the time-base clock and the low-speed sub clock. On entry it clears the watchdog. It keeps the power-down and watchdog time-out status flags that software reads after wake-up.

While the core is stopped, the block watches four wake sources: an external reset request, watchdog overflow, a pending interrupt, and a falling edge on any enabled port A pin. When a wake is registered, the block brings the system clock back, then restarts the core. It issues the reset class that suits the source. An external reset gives a full reset. A watchdog overflow resets only the program counter and stack pointer. An interrupt or a port edge gives no reset at all. A 3-bit reason code records which source won. The code is held until the next halt.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After reset the mode is run (code 0), the system clock enable and the core run strobe are 1, both status flags are 0 and the wake reason is 0 (none).
- R2: A halt strobe in run mode enters, at the next clock edge, sleep (code 1) when idle-enable is 0. It enters idle0 (code 2) when idle-enable is 1 and oscillator-keep-on is 0. It enters idle1 (code 3) when both are 1.
- R3: In sleep the system and time-base enables are 0 and the sub clock enable equals the watchdog-enable input. In idle0 the system enable is 0 and the time-base and sub enables are 1. In idle1 all three enables are 1. The core run strobe is 0 in every low-power mode.
- R4: An accepted halt sets the power-down flag, clears the time-out flag and the wake reason, and raises the watchdog clear output for exactly the first cycle of the low-power mode.
- R5: The clear-watchdog command clears the power-down flag at the next edge and leaves the time-out flag unchanged.
- R6: A wake source seen at an edge moves the mode to wake-clock (code 4). The system clock enable is 1 from the next cycle (wake-run, code 5), and the core run strobe is 1 from the cycle after that. During wake-clock the system clock enable stays 1 only when the block is leaving idle1.
- R7: A wake by external reset pulses the full-reset output during the wake-run cycle, gives reason 1 and leaves both flags unchanged.
- R8: A wake by watchdog overflow sets the time-out flag and pulses the program-counter/stack-pointer reset output during the wake-run cycle. It gives reason 2 and leaves the power-down flag unchanged.
- R9: A wake by interrupt (reason 3) or by a port A edge (reason 4) produces neither reset pulse.
- R10: When several sources are registered at the same edge, external reset wins over watchdog, watchdog over interrupt, and interrupt over port edge.
- R11: Only a falling edge on a pin whose wake-enable bit is 1 wakes the block. The edge is registered at the third clock edge after the pin falls. Rising edges, disabled pins, and any source that arrives outside a low-power mode change neither the mode nor the reason.
- R12: The wake reason stays unchanged in run mode until the next accepted halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Asynchronous active-low power-up reset |
| halt_i | input | 1 | Halt strobe from the core |
| idle_en_i | input | 1 | Idle-enable control bit |
| osc_keep_i | input | 1 | Keep the system oscillator on during idle |
| wdt_en_i | input | 1 | Watchdog enabled; keeps the sub clock on in sleep |
| clr_wdt_i | input | 1 | Clear-watchdog command from the core |
| ext_rst_i | input | 1 | External reset request |
| wdt_ovf_i | input | 1 | Watchdog overflow |
| irq_i | input | 1 | Pending interrupt |
| porta_i | input | NUM_PINS | Port A pin levels |
| porta_wake_en_i | input | NUM_PINS | Per-pin wake enable |
| sys_clk_en_o | output | 1 | System clock enable |
| tb_clk_en_o | output | 1 | Time-base clock enable |
| sub_clk_en_o | output | 1 | Sub clock enable |
| wdt_clr_o | output | 1 | Watchdog clear pulse |
| core_run_o | output | 1 | Core may execute |
| full_rst_o | output | 1 | Full system reset pulse |
| pc_sp_rst_o | output | 1 | Program counter and stack pointer reset pulse |
| pdf_o | output | 1 | Power-down flag |
| to_o | output | 1 | Watchdog time-out flag |
| wake_rsn_o | output | 3 | Wake reason: 0 none, 1 ext reset, 2 watchdog, 3 interrupt, 4 port |
| mode_o | output | 3 | Mode code: 0 run, 1 sleep, 2 idle0, 3 idle1, 4 wake-clock, 5 wake-run |

## Verification
Every combination of idle-enable, oscillator-keep-on and watchdog-enable is paired with each single wake source. This separates mode selection and clock gating from the effect of the source on resets and flags. All fifteen non-empty source subsets are then registered at the same edge, so that each pair of sources is ranked against the other. Each port pin is tried alone. Rising edges, disabled pins and sources that arrive in run mode are applied and must leave mode and reason unchanged.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;
  typedef enum logic [2:0] {
    PM_RUN   = 3'd0,
    PM_SLEEP = 3'd1,
    PM_IDLE0 = 3'd2,
    PM_IDLE1 = 3'd3,
    PM_WCLK  = 3'd4,
    PM_WRUN  = 3'd5
  } pm_state_e;

  typedef enum logic [2:0] {
    WR_NONE = 3'd0,
    WR_EXT  = 3'd1,
    WR_WDT  = 3'd2,
    WR_IRQ  = 3'd3,
    WR_PORT = 3'd4
  } wake_rsn_e;

  typedef struct packed {
    logic ext;
    logic wdt;
    logic irq;
    logic port;
  } wake_src_t;
endpackage

// File: rtl/pwr_port_fall.sv
module pwr_port_fall #(
  parameter int unsigned NUM_PINS  = 4,
  parameter int unsigned SYNC_LEN  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] en_i,
  output logic                fall_o
);
  localparam int unsigned LAST = SYNC_LEN - 1;

  logic [NUM_PINS-1:0] fall_pin;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [SYNC_LEN-1:0] sync_q;
    logic                prev_q;

    // reset to idle-high so no edge is seen right after reset
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q <= '1;
        prev_q <= 1'b1;
      end else begin
        sync_q <= {sync_q[SYNC_LEN-2:0], pin_i[p]};
        prev_q <= sync_q[LAST];
      end
    end

    assign fall_pin[p] = prev_q & ~sync_q[LAST] & en_i[p];
  end

  assign fall_o = |fall_pin;
endmodule

// File: rtl/pwr_wake_arb.sv
module pwr_wake_arb
  import pwr_wake_pkg::*;
(
  input  wake_src_t src_i,
  output logic      valid_o,
  output wake_rsn_e rsn_o
);
  always_comb begin
    valid_o = 1'b1;
    if (src_i.ext)       rsn_o = WR_EXT;
    else if (src_i.wdt)  rsn_o = WR_WDT;
    else if (src_i.irq)  rsn_o = WR_IRQ;
    else if (src_i.port) rsn_o = WR_PORT;
    else begin
      rsn_o   = WR_NONE;
      valid_o = 1'b0;
    end
  end
endmodule

// File: rtl/pwr_stat_flags.sv
module pwr_stat_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic halt_acc_i,
  input  logic clr_wdt_i,
  input  logic wdt_wake_i,
  output logic pdf_o,
  output logic to_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pdf_o <= 1'b0;
      to_o  <= 1'b0;
    end else begin
      if (halt_acc_i) begin
        pdf_o <= 1'b1;
        to_o  <= 1'b0;
      end else begin
        if (clr_wdt_i)  pdf_o <= 1'b0;
        if (wdt_wake_i) to_o  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_wake_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      halt_i,
  input  logic      idle_en_i,
  input  logic      osc_keep_i,
  input  logic      wake_vld_i,
  input  wake_rsn_e wake_rsn_i,
  output pm_state_e state_o,
  output logic      in_lp_o,
  output logic      halt_acc_o,
  output logic      wake_take_o,
  output logic      from_idle1_o,
  output wake_rsn_e rsn_o
);
  pm_state_e state_d;

  assign in_lp_o     = (state_o == PM_SLEEP) || (state_o == PM_IDLE0) ||
                       (state_o == PM_IDLE1);
  assign halt_acc_o  = (state_o == PM_RUN) && halt_i;
  assign wake_take_o = in_lp_o && wake_vld_i;

  always_comb begin
    state_d = state_o;
    unique case (state_o)
      PM_RUN: if (halt_i) begin
        if (!idle_en_i)      state_d = PM_SLEEP;
        else if (osc_keep_i) state_d = PM_IDLE1;
        else                 state_d = PM_IDLE0;
      end
      PM_SLEEP, PM_IDLE0, PM_IDLE1: if (wake_vld_i) state_d = PM_WCLK;
      PM_WCLK:  state_d = PM_WRUN;
      PM_WRUN:  state_d = PM_RUN;
      default:  state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o      <= PM_RUN;
      rsn_o        <= WR_NONE;
      from_idle1_o <= 1'b0;
    end else begin
      state_o <= state_d;
      if (halt_acc_o)       rsn_o <= WR_NONE;
      else if (wake_take_o) rsn_o <= wake_rsn_i;
      if (wake_take_o)      from_idle1_o <= (state_o == PM_IDLE1);
    end
  end
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
  import pwr_wake_pkg::*;
#(
  parameter int unsigned NUM_PINS = 4,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                halt_i,
  input  logic                idle_en_i,
  input  logic                osc_keep_i,
  input  logic                wdt_en_i,
  input  logic                clr_wdt_i,
  input  logic                ext_rst_i,
  input  logic                wdt_ovf_i,
  input  logic                irq_i,
  input  logic [NUM_PINS-1:0] porta_i,
  input  logic [NUM_PINS-1:0] porta_wake_en_i,
  output logic                sys_clk_en_o,
  output logic                tb_clk_en_o,
  output logic                sub_clk_en_o,
  output logic                wdt_clr_o,
  output logic                core_run_o,
  output logic                full_rst_o,
  output logic                pc_sp_rst_o,
  output logic                pdf_o,
  output logic                to_o,
  output logic [2:0]          wake_rsn_o,
  output logic [2:0]          mode_o
);
  logic      port_fall;
  wake_src_t src;
  logic      wake_vld;
  wake_rsn_e arb_rsn;
  pm_state_e state;
  logic      in_lp, halt_acc, wake_take, from_idle1;
  wake_rsn_e rsn;
  logic      wdt_clr_q;

  pwr_port_fall #(.NUM_PINS(NUM_PINS), .SYNC_LEN(SYNC_LEN)) u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (porta_i),
    .en_i   (porta_wake_en_i),
    .fall_o (port_fall)
  );

  assign src = '{ext: ext_rst_i, wdt: wdt_ovf_i, irq: irq_i, port: port_fall};

  pwr_wake_arb u_arb (
    .src_i   (src),
    .valid_o (wake_vld),
    .rsn_o   (arb_rsn)
  );

  pwr_mode_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .halt_i       (halt_i),
    .idle_en_i    (idle_en_i),
    .osc_keep_i   (osc_keep_i),
    .wake_vld_i   (wake_vld),
    .wake_rsn_i   (arb_rsn),
    .state_o      (state),
    .in_lp_o      (in_lp),
    .halt_acc_o   (halt_acc),
    .wake_take_o  (wake_take),
    .from_idle1_o (from_idle1),
    .rsn_o        (rsn)
  );

  pwr_stat_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .halt_acc_i (halt_acc),
    .clr_wdt_i  (clr_wdt_i),
    .wdt_wake_i (wake_take && (arb_rsn == WR_WDT)),
    .pdf_o      (pdf_o),
    .to_o       (to_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wdt_clr_q <= 1'b0;
    else         wdt_clr_q <= halt_acc;
  end

  assign sys_clk_en_o = (state == PM_RUN) || (state == PM_IDLE1) ||
                        (state == PM_WRUN) || ((state == PM_WCLK) && from_idle1);
  assign tb_clk_en_o  = (state != PM_SLEEP);
  assign sub_clk_en_o = (state != PM_SLEEP) || wdt_en_i;
  assign core_run_o   = (state == PM_RUN);
  assign full_rst_o   = (state == PM_WRUN) && (rsn == WR_EXT);
  assign pc_sp_rst_o  = (state == PM_WRUN) && (rsn == WR_WDT);
  assign wdt_clr_o    = wdt_clr_q;
  assign wake_rsn_o   = rsn;
  assign mode_o       = state;
endmodule

// File: rtl/pwr_wake_ctrl_chk.sv
module pwr_wake_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       halt_i,
  input logic       sys_clk_en_o,
  input logic       wdt_clr_o,
  input logic       core_run_o,
  input logic       full_rst_o,
  input logic       pc_sp_rst_o,
  input logic       pdf_o,
  input logic       to_o,
  input logic [2:0] wake_rsn_o,
  input logic [2:0] mode_o
);
  // R2
  halt_leaves_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd0 && halt_i) |=> (mode_o inside {3'd1, 3'd2, 3'd3}));

  // R3
  sleep_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd1) |-> (!sys_clk_en_o && !core_run_o));

  // R4
  halt_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd0 && halt_i) |=> (pdf_o && !to_o && wdt_clr_o && wake_rsn_o == 3'd0));

  // R6
  run_after_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_run_o) |-> $past(sys_clk_en_o));

  // R7
  one_reset_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_rst_o |-> (!pc_sp_rst_o && mode_o == 3'd5));

  // R8
  wdt_wake_sets_to_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_sp_rst_o |-> (to_o && wake_rsn_o == 3'd2));

  // R11
  run_stays_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd0 && !halt_i) |=> (mode_o == 3'd0));

  // R12
  rsn_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd0 && !halt_i) |=> $stable(wake_rsn_o));
endmodule

bind pwr_wake_ctrl pwr_wake_ctrl_chk u_chk (.*);

// File: tb/pwr_wake_ctrl_tb_top.sv
module pwr_wake_ctrl_tb_top;
  localparam int unsigned NP = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic halt = 0, idle_en = 0, osc_keep = 0, wdt_en = 0, clr_wdt = 0;
  logic ext_rst = 0, wdt_ovf = 0, irq = 0;
  logic [NP-1:0] porta = '1, wake_en = '1;
  logic sys_en, tb_en, sub_en, wdt_clr, core_run, full_rst, pcsp_rst, pdf, to_f;
  logic [2:0] rsn, mode;

  int n_chk = 0, n_fail = 0;
  logic pdf_e = 0, to_e = 0;
  logic [2:0] rsn_e = 0;

  always #4 clk = ~clk;

  pwr_wake_ctrl #(.NUM_PINS(NP)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .halt_i(halt), .idle_en_i(idle_en),
    .osc_keep_i(osc_keep), .wdt_en_i(wdt_en), .clr_wdt_i(clr_wdt),
    .ext_rst_i(ext_rst), .wdt_ovf_i(wdt_ovf), .irq_i(irq),
    .porta_i(porta), .porta_wake_en_i(wake_en),
    .sys_clk_en_o(sys_en), .tb_clk_en_o(tb_en), .sub_clk_en_o(sub_en),
    .wdt_clr_o(wdt_clr), .core_run_o(core_run), .full_rst_o(full_rst),
    .pc_sp_rst_o(pcsp_rst), .pdf_o(pdf), .to_o(to_f),
    .wake_rsn_o(rsn), .mode_o(mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_halt(input logic ie, input logic ok, input logic we);
    logic [2:0] m;
    idle_en = ie; osc_keep = ok; wdt_en = we; halt = 1;
    tick();
    halt = 0;
    m = !ie ? 3'd1 : (ok ? 3'd3 : 3'd2);
    pdf_e = 1; to_e = 0; rsn_e = 0;
    chk("R2 mode", mode, m);
    chk("R3 sys_en", sys_en, ie & ok);
    chk("R3 tb_en", tb_en, ie);
    chk("R3 sub_en", sub_en, ie | we);
    chk("R3 core_run", core_run, 0);
    chk("R4 pdf", pdf, 1);
    chk("R4 to", to_f, 0);
    chk("R4 rsn", rsn, 0);
    chk("R4 wdt_clr", wdt_clr, 1);
    tick();
    chk("R4 wdt_clr pulse", wdt_clr, 0);
    chk("R2 mode held", mode, m);
  endtask

  // mask: bit3 ext, bit2 wdt, bit1 irq, bit0 port (pin p)
  task automatic do_wake(input logic ie, input logic ok, input logic [3:0] mask, input int p);
    if (mask[0]) begin
      porta[p] = 0;
      tick(); tick();
    end
    ext_rst = mask[3]; wdt_ovf = mask[2]; irq = mask[1];
    tick();
    ext_rst = 0; wdt_ovf = 0; irq = 0;
    rsn_e = mask[3] ? 3'd1 : mask[2] ? 3'd2 : mask[1] ? 3'd3 : 3'd4;
    chk("R6 wclk mode", mode, 4);
    chk("R6 wclk sys_en", sys_en, ie & ok);
    chk("R6 wclk core_run", core_run, 0);
    tick();
    chk("R6 wrun mode", mode, 5);
    chk("R6 wrun sys_en", sys_en, 1);
    chk("R6 wrun core_run", core_run, 0);
    chk("R7 full_rst", full_rst, rsn_e == 3'd1);
    chk("R8 pc_sp_rst", pcsp_rst, rsn_e == 3'd2);
    tick();
    if (rsn_e == 3'd2) to_e = 1;
    chk("R6 run mode", mode, 0);
    chk("R6 core_run", core_run, 1);
    chk("R9 no full_rst", full_rst, 0);
    chk("R9 no pc_sp_rst", pcsp_rst, 0);
    chk("R10 rsn", rsn, rsn_e);
    chk("R8 to", to_f, to_e);
    chk("R7 pdf", pdf, pdf_e);
    porta = '1;
    repeat (4) tick();
    chk("R12 rsn held", rsn, rsn_e);
    chk("R12 mode run", mode, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1;
    tick();
    chk("R1 mode", mode, 0);
    chk("R1 sys_en", sys_en, 1);
    chk("R1 core_run", core_run, 1);
    chk("R1 pdf", pdf, 0);
    chk("R1 to", to_f, 0);
    chk("R1 rsn", rsn, 0);

    // configuration x single source sweep
    for (int c = 0; c < 8; c++) begin
      for (int s = 0; s < 4; s++) begin
        do_halt(c[2], c[1], c[0]);
        do_wake(c[2], c[1], 4'(1 << s), s);
      end
    end

    // all source subsets registered at one edge
    for (int m = 1; m < 16; m++) begin
      do_halt(1, 0, 0);
      do_wake(1, 0, 4'(m), m % NP);
    end

    // each pin alone
    for (int p = 0; p < NP; p++) begin
      do_halt(0, 0, 1);
      do_wake(0, 0, 4'b0001, p);
    end

    // disabled pin ignored, then interrupt wake
    for (int p = 0; p < NP; p++) begin
      wake_en = ~(NP'(1) << p);
      do_halt(1, 1, 0);
      porta[p] = 0;
      repeat (6) tick();
      chk("R11 disabled pin mode", mode, 3);
      chk("R11 disabled pin rsn", rsn, 0);
      porta = '1;
      tick();
      do_wake(1, 1, 4'b0010, 0);
      wake_en = '1;
    end

    // sources in run mode are ignored
    porta[1] = 0; irq = 1; wdt_ovf = 1; ext_rst = 1;
    tick();
    irq = 0; wdt_ovf = 0; ext_rst = 0;
    repeat (5) tick();
    chk("R11 run mode", mode, 0);
    chk("R11 run rsn", rsn, rsn_e);
    chk("R11 run to", to_f, to_e);
    chk("R11 run full_rst", full_rst, 0);
    // rising edge in low power ignored, then falling edge wakes
    do_halt(1, 0, 0);
    porta[1] = 1;
    repeat (6) tick();
    chk("R11 rising ignored", mode, 2);
    do_wake(1, 0, 4'b0001, 1);

    // watchdog wake then clear command
    do_halt(0, 0, 0);
    do_wake(0, 0, 4'b0100, 0);
    clr_wdt = 1;
    tick();
    clr_wdt = 0;
    chk("R5 pdf cleared", pdf, 0);
    chk("R5 to kept", to_f, 1);
    chk("R5 mode", mode, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule